// File: doc/BRIEF.md
# Program Memory Space Router

This block connects a processor's instruction fetch port to two program stores: an on-chip flash and an external parallel memory bus. Every fetch carries a 21-bit byte address, which covers a 2-Mbyte program space. The router compares that address against the size of on-chip memory. It then answers the fetch in one of three ways: with a flash word, with a zero word that the core executes as a no-operation, or with a word read over the external bus.

A 2-bit mode field sets the memory map. One mode keeps the external bus switched off. The other three modes let fetches fall through to the external bus, each with a different external address width. For external accesses, the external address can be rebased so that the first location past on-chip memory appears at external address zero. External accesses can be stretched by up to three wait states per read strobe. The external data bus is either 16 bits wide, or 8 bits wide with each instruction word assembled from two byte reads.

The configuration inputs are captured while reset is asserted and are frozen after reset releases, in the manner of write-once configuration. The core raises a request for one cycle and waits for the one-cycle ready pulse that carries the fetched word.

Top module: `pmem_router`

## Requirements
- R1: While reset is asserted, `fetch_rdy`, `ext_rd` and `fetch_data` are all 0.
- R2: The configuration inputs are captured on every clock edge at which `rst_n` is low. Changes to these inputs after reset release have no effect on routing, addressing, width or wait states.
- R3: For any fetch address below `ONCHIP_BYTES`, `fetch_data` returns the flash word present on `fl_rdata` while `fl_addr` equals the fetch address. The ready pulse comes one cycle after the request.
- R4: In internal-only mode (`cfg_mode` = 2'b11), a fetch at or above `ONCHIP_BYTES` returns 16'h0000 one cycle after the request and produces no external read strobe.
- R5: In the extended modes (`cfg_mode` = 2'b00, 2'b01 or 2'b10), a fetch at or above `ONCHIP_BYTES` goes to the external bus, with an address equal to `ONCHIP_BYTES` counted as external. A fetch below `ONCHIP_BYTES` still goes to flash.
- R6: When `cfg_addr_shift` is 1, the external address is the fetch address minus `ONCHIP_BYTES`. When it is 0, the external address is the fetch address.
- R7: The external address is truncated according to the mode, with the higher bits driven to 0. The widths are 12 bits for mode 2'b10, 16 bits for mode 2'b01 and 20 bits for mode 2'b00.
- R8: Each external read strobe lasts `cfg_wait_cnt`+1 cycles when `cfg_wait_off` is 0. It lasts exactly 1 cycle when `cfg_wait_off` is 1. `ext_addr` is held stable for the whole strobe.
- R9: When `cfg_bus_wide` is 1, `ext_wide` is 1 and one 16-bit read supplies the whole instruction word.
- R10: When `cfg_bus_wide` is 0, two byte reads are made, from the external address and then from the external address plus 1. The first byte lands in `fetch_data[7:0]` and the second in `fetch_data[15:8]`. Only `ext_rdata[7:0]` is used.
- R11: `fetch_rdy` is a single-cycle pulse for each request. For an external fetch it comes N×(W+1)+1 cycles after the request, where N is the number of reads and W is the effective number of wait states.
- R12: `fetch_rdy` and `ext_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_mode | input | 2 | Memory map mode: 11 internal only, 10/01/00 extended with 12/16/20-bit external address |
| cfg_addr_shift | input | 1 | 1 rebases the external address to start at 0 |
| cfg_wait_off | input | 1 | 1 disables wait states on external reads |
| cfg_bus_wide | input | 1 | 1 selects a 16-bit external data bus, 0 selects an 8-bit bus |
| cfg_wait_cnt | input | 2 | Number of wait states per external read strobe |
| fetch_req | input | 1 | One-cycle fetch request; sampled only when the block is idle |
| fetch_addr | input | 21 | Byte address of the instruction word (even) |
| fetch_rdy | output | 1 | One-cycle pulse; `fetch_data` is valid |
| fetch_data | output | 16 | Fetched instruction word |
| fl_addr | output | 21 | Address to the on-chip flash |
| fl_rdata | input | 16 | Flash read word, valid in the same cycle as `fl_addr` |
| ext_rd | output | 1 | External read strobe |
| ext_wide | output | 1 | External data bus width in use (1 = 16-bit) |
| ext_addr | output | 20 | External byte address |
| ext_rdata | input | 16 | External read data, sampled in the last cycle of a strobe |

## Verification
The hardest situation to reach is proving that the frozen configuration really is frozen. From the ports, a live configuration and a latched one look the same unless the inputs move after reset. The stimulus therefore drives every configuration input to its opposite value right after each reset release. It then repeats fetches whose expected results depend on the original settings, so a design that read the live inputs would route or time those fetches differently. The byte-assembly path with three wait states and a 16-bit mask is also reached only by a specific reset configuration. One fetch there is placed so that the second byte address lands on the last location inside the mask.

// File: rtl/pmem_router_pkg.sv
// Shared types for the program memory space router.
// Assumes the mode field encoding is fixed by the configuration word layout.
package pmem_router_pkg;

    localparam int PM_WAIT_W = 2;

    typedef enum logic [1:0] {
        MODE_EXT20 = 2'b00,
        MODE_EXT16 = 2'b01,
        MODE_EXT12 = 2'b10,
        MODE_INT   = 2'b11
    } pm_mode_e;

    typedef struct packed {
        pm_mode_e               mode;
        logic                   shift;
        logic                   nowait;
        logic                   wide;
        logic [PM_WAIT_W-1:0]   waits;
    } pm_cfg_t;

    typedef enum logic [1:0] {
        TGT_FLASH = 2'b00,
        TGT_ZERO  = 2'b01,
        TGT_EXT   = 2'b10
    } pm_tgt_e;

endpackage

// File: rtl/pmem_cfg_latch.sv
// Configuration capture: loads the configuration while reset is low and
// freezes it afterwards (write-once behaviour).
// Assumes rst_n is held low for at least one clock edge with valid inputs.
module pmem_cfg_latch
    import pmem_router_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pm_cfg_t cfg_in,
    output pm_cfg_t cfg_q
);

    // Capture configuration during reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_in;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q)); // R2

endmodule

// File: rtl/pmem_addr_map.sv
// Address decoder: chooses the target of a fetch (flash, zero word or
// external bus) and forms the unmasked external base address.
// Assumes ONCHIP_BYTES fits within the ADDR_W address space.
module pmem_addr_map
    import pmem_router_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int EXT_W        = 20,
    parameter int ONCHIP_BYTES = 65536
) (
    input  pm_cfg_t           cfg,
    input  logic [ADDR_W-1:0] fetch_addr,
    output pm_tgt_e           tgt,
    output logic [EXT_W-1:0]  ext_base
);

    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(ONCHIP_BYTES);

    logic above;

    // Pick the target; an address equal to TOP counts as external.
    always_comb begin
        above = (fetch_addr >= TOP);
        if (!above)                   tgt = TGT_FLASH;
        else if (cfg.mode == MODE_INT) tgt = TGT_ZERO;
        else                          tgt = TGT_EXT;
    end

    // Optional rebase so that the first external location sits at zero.
    always_comb begin
        if (cfg.shift) ext_base = EXT_W'(fetch_addr - TOP);
        else           ext_base = EXT_W'(fetch_addr);
    end

endmodule

// File: rtl/pmem_fetch_seq.sv
// Fetch sequencer: answers flash and zero fetches in one cycle, runs the
// external read strobes with wait states, assembles bytes in 8-bit mode.
// Assumes the core issues no new request until fetch_rdy has pulsed.
module pmem_fetch_seq
    import pmem_router_pkg::*;
#(
    parameter int EXT_W  = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pm_cfg_t           cfg,
    input  logic              fetch_req,
    input  pm_tgt_e           tgt,
    input  logic [EXT_W-1:0]  ext_base,
    input  logic [DATA_W-1:0] fl_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              fetch_rdy,
    output logic [DATA_W-1:0] fetch_data,
    output logic              ext_rd,
    output logic [EXT_W-1:0]  ext_addr
);

    localparam int BYTE_W = DATA_W / 2;

    typedef enum logic {S_IDLE, S_XFER} seq_state_e;

    seq_state_e             state;
    logic [EXT_W-1:0]       base_q;
    logic [PM_WAIT_W-1:0]   wleft;
    logic                   hi_byte;
    logic [BYTE_W-1:0]      lo_q;
    logic [PM_WAIT_W-1:0]   waits_eff;
    logic [EXT_W-1:0]       raw_addr;

    // Effective wait states per strobe.
    always_comb waits_eff = cfg.nowait ? '0 : cfg.waits;

    // External address: base plus byte index, masked by mode width.
    always_comb begin
        raw_addr = base_q + EXT_W'(hi_byte);
        case (cfg.mode)
            MODE_EXT12: ext_addr = raw_addr & EXT_W'(20'h00FFF);
            MODE_EXT16: ext_addr = raw_addr & EXT_W'(20'h0FFFF);
            default:    ext_addr = raw_addr;
        endcase
        ext_rd = (state == S_XFER);
    end

    // Fetch state machine and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            fetch_rdy  <= 1'b0;
            fetch_data <= '0;
            base_q     <= '0;
            wleft      <= '0;
            hi_byte    <= 1'b0;
            lo_q       <= '0;
        end else begin
            fetch_rdy <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (fetch_req) begin
                        case (tgt)
                            TGT_FLASH: begin
                                fetch_data <= fl_rdata;
                                fetch_rdy  <= 1'b1;
                            end
                            TGT_ZERO: begin
                                fetch_data <= '0;
                                fetch_rdy  <= 1'b1;
                            end
                            default: begin
                                base_q  <= ext_base;
                                wleft   <= waits_eff;
                                hi_byte <= 1'b0;
                                state   <= S_XFER;
                            end
                        endcase
                    end
                end
                default: begin
                    if (wleft != '0) begin
                        wleft <= wleft - 1'b1;
                    end else if (cfg.wide) begin
                        fetch_data <= ext_rdata;
                        fetch_rdy  <= 1'b1;
                        state      <= S_IDLE;
                    end else if (!hi_byte) begin
                        lo_q    <= ext_rdata[BYTE_W-1:0];
                        hi_byte <= 1'b1;
                        wleft   <= waits_eff;
                    end else begin
                        fetch_data <= {ext_rdata[BYTE_W-1:0], lo_q};
                        fetch_rdy  <= 1'b1;
                        hi_byte    <= 1'b0;
                        state      <= S_IDLE;
                    end
                end
            endcase
        end
    end

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd && wleft != '0) |=> (ext_rd && $stable(ext_addr))); // R8

    AST_RDY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && fetch_rdy)); // R12

    AST_WIDE_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd && cfg.wide && wleft == '0) |=> (fetch_rdy && !ext_rd)); // R9

    AST_NOWAIT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd && cfg.nowait) |-> (wleft == '0)); // R8

endmodule

// File: rtl/pmem_router.sv
// Program memory space router top: latches configuration at reset, decodes
// each fetch address, and sequences flash, zero or external responses.
// Assumes even fetch addresses and one outstanding fetch at a time.
module pmem_router
    import pmem_router_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int EXT_W        = 20,
    parameter int DATA_W       = 16,
    parameter int ONCHIP_BYTES = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_addr_shift,
    input  logic              cfg_wait_off,
    input  logic              cfg_bus_wide,
    input  logic [1:0]        cfg_wait_cnt,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_rdy,
    output logic [DATA_W-1:0] fetch_data,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              ext_rd,
    output logic              ext_wide,
    output logic [EXT_W-1:0]  ext_addr,
    input  logic [DATA_W-1:0] ext_rdata
);

    pm_cfg_t          cfg_in;
    pm_cfg_t          cfg_q;
    pm_tgt_e          tgt;
    logic [EXT_W-1:0] ext_base;

    // Pack the raw configuration pins.
    always_comb begin
        cfg_in.mode   = pm_mode_e'(cfg_mode);
        cfg_in.shift  = cfg_addr_shift;
        cfg_in.nowait = cfg_wait_off;
        cfg_in.wide   = cfg_bus_wide;
        cfg_in.waits  = cfg_wait_cnt;
        fl_addr       = fetch_addr;
        ext_wide      = cfg_q.wide;
    end

    pmem_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    pmem_addr_map #(
        .ADDR_W       (ADDR_W),
        .EXT_W        (EXT_W),
        .ONCHIP_BYTES (ONCHIP_BYTES)
    ) u_map (
        .cfg        (cfg_q),
        .fetch_addr (fetch_addr),
        .tgt        (tgt),
        .ext_base   (ext_base)
    );

    pmem_fetch_seq #(
        .EXT_W  (EXT_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .fetch_req  (fetch_req),
        .tgt        (tgt),
        .ext_base   (ext_base),
        .fl_rdata   (fl_rdata),
        .ext_rdata  (ext_rdata),
        .fetch_rdy  (fetch_rdy),
        .fetch_data (fetch_data),
        .ext_rd     (ext_rd),
        .ext_addr   (ext_addr)
    );

    AST_INT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_INT) |-> !ext_rd); // R4

    AST_MASK12: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd && cfg_q.mode == MODE_EXT12) |-> (ext_addr[EXT_W-1:12] == '0)); // R7

    AST_MASK16: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd && cfg_q.mode == MODE_EXT16) |-> (ext_addr[EXT_W-1:16] == '0)); // R7

endmodule

// File: tb/pmem_router_test.sv
`timescale 1ns/1ps
module pmem_router_test;

    localparam int TOP = 65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b11;
    logic        cfg_addr_shift = 1'b0;
    logic        cfg_wait_off = 1'b0;
    logic        cfg_bus_wide = 1'b0;
    logic [1:0]  cfg_wait_cnt = 2'b00;
    logic        fetch_req = 1'b0;
    logic [20:0] fetch_addr = '0;
    logic        fetch_rdy;
    logic [15:0] fetch_data;
    logic [20:0] fl_addr;
    logic [15:0] fl_rdata;
    logic        ext_rd;
    logic        ext_wide;
    logic [19:0] ext_addr;
    logic [15:0] ext_rdata;

    pmem_router uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_addr_shift(cfg_addr_shift),
        .cfg_wait_off(cfg_wait_off), .cfg_bus_wide(cfg_bus_wide),
        .cfg_wait_cnt(cfg_wait_cnt),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rdy(fetch_rdy), .fetch_data(fetch_data),
        .fl_addr(fl_addr), .fl_rdata(fl_rdata),
        .ext_rd(ext_rd), .ext_wide(ext_wide),
        .ext_addr(ext_addr), .ext_rdata(ext_rdata)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] fl_word(logic [20:0] a);
        return a[15:0] ^ 16'h3C3C ^ {11'h0, a[20:16]};
    endfunction
    function automatic logic [15:0] ext_word(logic [19:0] a);
        return a[15:0] ^ {a[19:12], 8'h00} ^ 16'hA5C3;
    endfunction
    function automatic logic [7:0] ext_byte(logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h69;
    endfunction

    assign fl_rdata  = fl_word(fl_addr);
    assign ext_rdata = ext_wide ? ext_word(ext_addr) : {8'hEE, ext_byte(ext_addr)};

    typedef struct {
        logic [15:0] data;
        int          lat;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int strobes = 0;
    int excl_viol = 0;
    bit finished = 0;

    logic [1:0] m_mode;
    logic       m_shift, m_nowait, m_wide;
    logic [1:0] m_waits;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Cycle and strobe counters sampled on the active edge.
    always @(posedge clk) begin
        if (fetch_req) cyc <= 0; else cyc <= cyc + 1;
        if (ext_rd) strobes <= strobes + 1;
    end

    // Monitor: pops the scoreboard on each ready pulse.
    always @(negedge clk) begin
        if (rst_n && ext_rd && fetch_rdy) excl_viol++;
        if (rst_n && fetch_rdy) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected ready", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(fetch_data == e.data, e.tag, "data", fetch_data, e.data);
                check(cyc + 1 == e.lat, "R11", "latency", cyc + 1, e.lat);
            end
        end
    end

    function automatic logic [19:0] mask_ext(logic [19:0] a);
        case (m_mode)
            2'b10:   return a & 20'h00FFF;
            2'b01:   return a & 20'h0FFFF;
            default: return a;
        endcase
    endfunction

    task automatic do_reset(logic [1:0] md, logic sh, logic nw, logic wd, logic [1:0] ws);
        m_mode = md; m_shift = sh; m_nowait = nw; m_wide = wd; m_waits = ws;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = md; cfg_addr_shift = sh; cfg_wait_off = nw;
        cfg_bus_wide = wd; cfg_wait_cnt = ws;
        repeat (3) @(negedge clk);
        check(!fetch_rdy && !ext_rd && fetch_data == 16'h0, "R1", "reset outputs",
              {fetch_rdy, ext_rd, fetch_data}, 0);
        rst_n = 1'b1;
        // R2: scramble all configuration pins after release.
        cfg_mode = ~md; cfg_addr_shift = ~sh; cfg_wait_off = ~nw;
        cfg_bus_wide = ~wd; cfg_wait_cnt = ~ws;
        @(negedge clk);
        check(ext_wide == wd, "R9", "ext_wide", ext_wide, wd);
    endtask

    task automatic fetch(logic [20:0] a, string tag);
        exp_t e;
        logic [19:0] ea;
        int nrd, w, s0;
        nrd = 0;
        w = m_nowait ? 0 : int'(m_waits);
        if (a < 21'(TOP)) begin
            e.data = fl_word(a);
        end else if (m_mode == 2'b11) begin
            e.data = 16'h0;
        end else begin
            ea = m_shift ? 20'(a - 21'(TOP)) : 20'(a);
            ea = mask_ext(ea);
            if (m_wide) begin
                e.data = ext_word(ea);
                nrd = 1;
            end else begin
                e.data = {ext_byte(mask_ext(ea + 20'd1)), ext_byte(ea)};
                nrd = 2;
            end
        end
        e.lat = (nrd == 0) ? 1 : nrd * (w + 1) + 1;
        e.tag = tag;
        s0 = strobes;
        sb.push_back(e);
        @(negedge clk);
        fetch_req = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        check(!fetch_rdy, "R11", "ready single pulse", fetch_rdy, 0);
        check(strobes - s0 == nrd * (w + 1), (nrd == 0) ? "R4" : "R8",
              "strobe cycles", strobes - s0, nrd * (w + 1));
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "timeout", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Internal-only mode.
        do_reset(2'b11, 1'b0, 1'b0, 1'b1, 2'b01);
        fetch(21'h000100, "R3");
        fetch(21'h010000, "R4");
        fetch(21'h1FFFFE, "R4");
        fetch(21'h018000, "R2");
        // Extended 20-bit, no shift, no waits, wide.
        do_reset(2'b00, 1'b0, 1'b1, 1'b1, 2'b11);
        fetch(21'h00FFFE, "R5");
        fetch(21'h010000, "R5");
        fetch(21'h1ABCDE, "R7");
        // Extended 12-bit, shift, 2 waits, wide.
        do_reset(2'b10, 1'b1, 1'b0, 1'b1, 2'b10);
        fetch(21'h010000, "R6");
        fetch(21'h012346, "R7");
        fetch(21'h000400, "R3");
        // Extended 16-bit, no shift, 3 waits, byte bus.
        do_reset(2'b01, 1'b0, 1'b0, 1'b0, 2'b11);
        fetch(21'h01F0A4, "R10");
        fetch(21'h03FFFE, "R7");
        // Extended 20-bit, shift, waits off, byte bus.
        do_reset(2'b00, 1'b1, 1'b1, 1'b0, 2'b11);
        fetch(21'h030000, "R6");
        fetch(21'h1FFFFE, "R10");
        check(excl_viol == 0, "R12", "ready with strobe", excl_viol, 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule